// File: doc/BRIEF.md
# Four-Bit Bit-Slice Arithmetic Logic Unit

This block is a small arithmetic logic unit assembled from identical one-bit slices. Each slice has three stages. A 4-to-1 input multiplexer picks the second adder operand: B, inverted B, all zeros or all ones. A full adder follows. A 2-to-1 output multiplexer then returns either the adder sum or a bitwise logic result. The carry ripples from the least significant slice to the most significant one.

A shared decoder turns a 3-bit operation code into the slice controls. Those controls are the operand source, the carry-in, the logic function and the output source. Four arithmetic operations and four bitwise operations all pass through the same slice structure.

A flag stage derives carry, zero, sign and even-parity status from the result. The result and the flags are captured together in one output register for timing closure. They therefore appear one clock after the inputs are sampled.

Top module: `slice_alu`

## Requirements
- R1: While rst_ni is low, h_o and all four flags are 0.
- R2: Operation code 3'b000 (add) gives h_o = (a_i + b_i) mod 2^W one clock after sampling, and carry_o is the carry out of the top slice.
- R3: Operation code 3'b001 (subtract) gives h_o = (a_i - b_i) mod 2^W, and carry_o = 1 exactly when no borrow occurs (a_i >= b_i unsigned).
- R4: Operation code 3'b010 (increment) gives h_o = (a_i + 1) mod 2^W, with carry_o = 1 only when a_i is all ones. b_i has no effect.
- R5: Operation code 3'b011 (decrement) gives h_o = (a_i - 1) mod 2^W, with carry_o = 1 exactly when a_i is nonzero. b_i has no effect.
- R6: The bitwise operations are 3'b100 AND, 3'b101 OR, 3'b110 XOR and 3'b111 XNOR. For each of them carry_o is 0.
- R7: zero_o is 1 exactly when h_o is 0.
- R8: sign_o equals the most significant bit of h_o.
- R9: parity_o is 1 exactly when h_o holds an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| op_i | input | 3 | Operation code |
| h_o | output | W | Registered result |
| carry_o | output | 1 | Carry / no-borrow flag |
| zero_o | output | 1 | Result-is-zero flag |
| sign_o | output | 1 | Result MSB |
| parity_o | output | 1 | Even-parity flag |

## Verification
The bench targets the full ripple, as in 4'hF + 4'h1, 4'hF increment and 4'h0 decrement. A broken carry chain there would leave upper bits or carry_o wrong. Subtraction with equal operands and with a_i just below b_i exposes an inverted borrow sense or a missing carry-in of 1. Increment and decrement are run with random b_i to show the operand mux really substitutes a constant. Bitwise operations are run on operands that would produce an adder carry, so a carry flag that is not masked shows up.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_DEC  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_XNOR = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    BSRC_PASS = 2'b00,
    BSRC_INV  = 2'b01,
    BSRC_ZERO = 2'b10,
    BSRC_ONES = 2'b11
  } bsrc_e;

  typedef enum logic [1:0] {
    LFN_AND  = 2'b00,
    LFN_OR   = 2'b01,
    LFN_XOR  = 2'b10,
    LFN_XNOR = 2'b11
  } lfn_e;

  typedef struct packed {
    bsrc_e bsrc;
    logic  cin;
    lfn_e  lfn;
    logic  use_logic;
  } slice_ctrl_t;
endpackage

// File: rtl/slice_alu_ctrl.sv
module slice_alu_ctrl
  import slice_alu_pkg::*;
(
  input  logic [2:0]  op_i,
  output slice_ctrl_t ctrl_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o.bsrc      = BSRC_PASS;
    ctrl_o.cin       = 1'b0;
    ctrl_o.lfn       = lfn_e'(op_i[1:0]);
    ctrl_o.use_logic = op_i[2];
    unique case (op)
      OP_SUB: begin ctrl_o.bsrc = BSRC_INV;  ctrl_o.cin = 1'b1; end
      OP_INC: begin ctrl_o.bsrc = BSRC_ZERO; ctrl_o.cin = 1'b1; end
      OP_DEC: begin ctrl_o.bsrc = BSRC_ONES; ctrl_o.cin = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
  import slice_alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        cin_i,
  input  slice_ctrl_t ctrl_i,
  output logic        h_o,
  output logic        cout_o
);
  logic b_sel, sum, lres;

  // input stage: adder operand select
  always_comb begin
    unique case (ctrl_i.bsrc)
      BSRC_PASS: b_sel = b_i;
      BSRC_INV:  b_sel = ~b_i;
      BSRC_ZERO: b_sel = 1'b0;
      default:   b_sel = 1'b1;
    endcase
  end

  assign sum    = a_i ^ b_sel ^ cin_i;
  assign cout_o = (a_i & b_sel) | (a_i & cin_i) | (b_sel & cin_i);

  always_comb begin
    unique case (ctrl_i.lfn)
      LFN_AND: lres = a_i & b_i;
      LFN_OR:  lres = a_i | b_i;
      LFN_XOR: lres = a_i ^ b_i;
      default: lres = ~(a_i ^ b_i);
    endcase
  end

  // output stage: adder vs logic
  assign h_o = ctrl_i.use_logic ? lres : sum;
endmodule

// File: rtl/slice_alu_flags.sv
module slice_alu_flags #(
  parameter int W = 4
) (
  input  logic [W-1:0] h_i,
  input  logic         cout_i,
  input  logic         use_logic_i,
  output logic [3:0]   flags_o // {carry, zero, sign, parity}
);
  assign flags_o[3] = cout_i & ~use_logic_i;
  assign flags_o[2] = (h_i == '0);
  assign flags_o[1] = h_i[W-1];
  assign flags_o[0] = ~^h_i;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] h_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic         parity_o
);
  slice_ctrl_t  ctrl;
  logic [W:0]   chain;
  logic [W-1:0] h_d;
  logic [3:0]   flags_d;
  logic         primed_q;

  slice_alu_ctrl u_ctrl (.op_i(op_i), .ctrl_o(ctrl));

  assign chain[0] = ctrl.cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    slice_alu_bit u_bit (
      .a_i(a_i[i]), .b_i(b_i[i]), .cin_i(chain[i]), .ctrl_i(ctrl),
      .h_o(h_d[i]), .cout_o(chain[i+1])
    );
  end

  slice_alu_flags #(.W(W)) u_flags (
    .h_i(h_d), .cout_i(chain[W]), .use_logic_i(ctrl.use_logic), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o      <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      sign_o   <= 1'b0;
      parity_o <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      h_o      <= h_d;
      {carry_o, zero_o, sign_o, parity_o} <= flags_d;
      primed_q <= 1'b1;
    end
  end

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_ADD |->
      {carry_o, h_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})); // R2
  AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_SUB |->
      carry_o == ($past(a_i) >= $past(b_i))); // R3
  AST_INC_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_INC |->
      {carry_o, h_o} == ({1'b0, $past(a_i)} + (W+1)'(1))); // R4
  AST_DEC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_DEC |-> carry_o == ($past(a_i) != '0)); // R5
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i[2]) |-> !carry_o); // R6
  AST_ZERO_NOT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> !sign_o && h_o == '0); // R7
endmodule

// File: tb/slice_alu_tb.sv
module slice_alu_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   op = '0;
  logic [W-1:0] h;
  logic         carry, zero, sign, parity;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  slice_alu #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .op_i(op),
    .h_o(h), .carry_o(carry), .zero_o(zero), .sign_o(sign), .parity_o(parity)
  );

  // expected {carry, h}
  function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    int xi = int'(x), yi = int'(y), m = 1 << W;
    case (o)
      3'd0: return (W+1)'(xi + yi);
      3'd1: return {logic'(xi >= yi), W'((xi - yi + m) % m)};
      3'd2: return (W+1)'(xi + 1);
      3'd3: return {logic'(xi != 0), W'((xi + m - 1) % m)};
      3'd4: return {1'b0, x & y};
      3'd5: return {1'b0, x | y};
      3'd6: return {1'b0, x ^ y};
      default: return {1'b0, ~(x ^ y)};
    endcase
  endfunction

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (op=%0d a=%0h b=%0h)", tag, act, exp, op, a, b);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] e;
    string t;
    @(negedge clk);
    op = o; a = x; b = y;
    e = model(o, x, y);
    @(posedge clk);
    #2;
    case (o)
      3'd0: t = "R2"; 3'd1: t = "R3"; 3'd2: t = "R4"; 3'd3: t = "R5";
      default: t = "R6";
    endcase
    chk(t, int'(h), int'(e[W-1:0]));
    chk(t, int'(carry), int'(e[W]));
    chk("R7", int'(zero), int'(e[W-1:0] == '0));
    chk("R8", int'(sign), int'(e[W-1]));
    chk("R9", int'(parity), int'(ones(e[W-1:0]) % 2 == 0));
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds outputs low
    op = 3'd0; a = 4'hF; b = 4'h1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", int'(h), 0);
    chk("R1", int'({carry, zero, sign, parity}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // directed corners
    run(3'd0, 4'hF, 4'h1);  // R2 full ripple
    run(3'd0, 4'h0, 4'h0);  // R2 zero
    run(3'd1, 4'h5, 4'h5);  // R3 equal, no borrow
    run(3'd1, 4'h4, 4'h5);  // R3 borrow
    run(3'd1, 4'h0, 4'hF);  // R3
    run(3'd2, 4'hF, 4'h7);  // R4 wrap, b ignored
    run(3'd2, 4'h7, 4'hF);  // R4
    run(3'd3, 4'h0, 4'h3);  // R5 wrap, b ignored
    run(3'd3, 4'h8, 4'h0);  // R5
    run(3'd4, 4'hF, 4'hF);  // R6 carry masked
    run(3'd5, 4'hA, 4'h5);  // R6
    run(3'd6, 4'hC, 4'hC);  // R6 zero result
    run(3'd7, 4'hC, 4'hA);  // R6
    for (int i = 0; i < 600; i++)
      run(3'($urandom_range(7)), W'($urandom), W'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule